// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes an incoming frame as a byte stream and stores it in a circular buffer inside local packet memory. The buffer is built from 256-byte pages, and software defines its first page, its end page and the page up to which it has already consumed data. The block owns the current page register. That register points at the page where the next frame will begin.

Each stored frame starts with a four-byte header. The header holds a status byte, a link to the page where the following frame starts, and the stored length. The frame's data bytes come after the header. Frames shorter than the minimum are padded with zeros. When the data reaches the end of the ring, it continues at the first page.

Before a frame begins, the block decides whether the ring has room for a frame of maximum size. It refuses the frame when there is not enough room or when the controller is stopped. Once a frame is complete, the current page advances to the link value, and a one-cycle pulse tells the interrupt logic that a frame was received.

Top module: `rxr_ring_writer`

## Requirements
- R1: The byte address of a page is the page number times 256. `rx_ready` is high only when the block is idle, the controller is not stopped and the free space is at least 1518 bytes. Free space counts 256 bytes per free page, where free pages = `pg_bound - cur_page` when `cur_page < pg_bound`, else `(pg_stop - pg_start) - (cur_page - pg_bound)`.
- R2: A frame whose `rx_start` arrives while `rx_ready` is low is dropped. It causes no memory write and no `rx_done`, and `cur_page` keeps its value.
- R3: The data bytes of an accepted frame are written in arrival order, one per valid cycle. They start at address `cur_page*256 + 4` and each lands one byte after the previous one.
- R4: When a frame has fewer than 60 data bytes, zero bytes are written after its data until 60 bytes are stored.
- R5: After the data and any padding, the header is written at `base*256` through `base*256 + 3`, in that order. Byte 0 is the status 0x01. Byte 2 is the low byte and byte 3 the high byte of the total, which is the stored length plus 4.
- R6: Header byte 1 and the new `cur_page` both equal the next page. The next page is base + ((total + 4 + 255) / 256), rounded down. If that value is at or beyond `pg_stop`, `(pg_stop - pg_start)` is subtracted from it.
- R7: A data or pad write whose address would reach `pg_stop*256` goes to `pg_start*256` instead. Every write stays inside the ring.
- R8: `rx_done` is high for exactly one cycle. That cycle is the one in which the last header byte is written, and `cur_page` already shows the next page in it.
- R9: While a frame is in progress, `rx_ready` is low and any further `rx_start` is ignored.
- R10: After reset, `cur_page` is 0 and `rx_done` and `mem_we` are low. `cur_load` copies `cur_load_pg` into `cur_page` only while idle and is ignored during a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_stopped | input | 1 | Controller stopped; refuses new frames |
| pg_start | input | 8 | First page of the ring |
| pg_stop | input | 8 | Page one past the end of the ring |
| pg_bound | input | 8 | First page not yet consumed by software |
| cur_load | input | 1 | Load the current page (idle only) |
| cur_load_pg | input | 8 | Value for a current-page load |
| rx_start | input | 1 | Frame start strobe, one cycle before the first byte |
| rx_valid | input | 1 | Data byte valid |
| rx_data | input | 8 | Data byte |
| rx_last | input | 1 | Marks the final valid byte of a frame |
| rx_ready | output | 1 | A frame start would be accepted |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_page | output | 8 | Current page register |
| rx_done | output | 1 | One-cycle frame-received pulse |

## Verification
The assertions that keep writes inside the ring rely on these input conditions:
- `pg_start` is below `pg_stop`.
- The page registers do not change while a frame is in progress.
- Any page loaded into `cur_page` lies within the ring.

The stimulus sets up the ring and the boundary only while the block is idle, and every value it loads is a page inside the ring. It starts frames only as `rx_start` pulses with `rx_valid` bytes following. It ends each frame with `rx_last` on a valid byte. The bench's reference model is a queue of expected writes compared on every clock. That model assumes the memory accepts a write in every cycle.

// File: rtl/rxr_pkg.sv
// Package: shared constants and state type for the receive ring writer.
// Assumes 256-byte pages; every address is a page number followed by a byte offset.
package rxr_pkg;

    localparam int PAGE_SHIFT = 8;
    localparam int HDR_BYTES  = 4;
    localparam int CRC_SLACK  = 4;
    localparam logic [7:0] RX_STATUS_GOOD = 8'h01;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_DATA,
        RX_PAD,
        RX_HDR
    } rx_state_e;

endpackage

// File: rtl/rxr_space.sv
// Module: free-space test for the ring.
// Counts the free pages between the current page and the boundary, taking the
// wrap into account, and reports whether at least NEED_BYTES would fit.
// Assumes start_pg < stop_pg and that cur_pg and bound_pg lie inside the ring.
module rxr_space
    import rxr_pkg::*;
#(
    parameter int PG_W       = 8,
    parameter int NEED_BYTES = 1518
) (
    input  logic [PG_W-1:0] start_pg,
    input  logic [PG_W-1:0] stop_pg,
    input  logic [PG_W-1:0] bound_pg,
    input  logic [PG_W-1:0] cur_pg,
    output logic            has_room
);

    localparam int PAGE_BYTES = 1 << PAGE_SHIFT;

    int free_pg;

    // Free page count; when current is not below the boundary, the gap is taken out of the ring size.
    always_comb begin
        if (cur_pg < bound_pg) begin
            free_pg = int'(bound_pg) - int'(cur_pg);
        end else begin
            free_pg = (int'(stop_pg) - int'(start_pg)) - (int'(cur_pg) - int'(bound_pg));
        end
        has_room = ((free_pg * PAGE_BYTES) >= NEED_BYTES);
    end

endmodule

// File: rtl/rxr_next.sv
// Module: next-page calculator.
// Advances the base page by the number of pages the frame takes, leaving room
// for the checksum, and wraps the result back into the ring when it reaches the stop page.
// Assumes one wrap is enough, which holds while a frame is smaller than the ring.
module rxr_next
    import rxr_pkg::*;
#(
    parameter int PG_W  = 8,
    parameter int LEN_W = 16
) (
    input  logic [PG_W-1:0]  base_pg,
    input  logic [LEN_W-1:0] total_len,
    input  logic [PG_W-1:0]  start_pg,
    input  logic [PG_W-1:0]  stop_pg,
    output logic [PG_W-1:0]  next_pg
);

    localparam int PAGE_MASK = (1 << PAGE_SHIFT) - 1;

    int span;
    int cand;

    // Page count rounded up with the checksum slack, then wrapped at the stop page.
    always_comb begin
        span = (int'(total_len) + CRC_SLACK + PAGE_MASK) >> PAGE_SHIFT;
        cand = int'(base_pg) + span;
        if (cand >= int'(stop_pg)) begin
            cand = cand - (int'(stop_pg) - int'(start_pg));
        end
        next_pg = PG_W'(cand);
    end

endmodule

// File: rtl/rxr_step.sv
// Module: ring address stepper.
// Gives the byte address that follows addr_in, jumping to the first byte of
// the start page when the stop page would be reached.
// Assumes addr_in already lies inside the ring.
module rxr_step
    import rxr_pkg::*;
#(
    parameter int PG_W = 8
) (
    input  logic [PG_W+PAGE_SHIFT-1:0] addr_in,
    input  logic [PG_W-1:0]            start_pg,
    input  logic [PG_W-1:0]            stop_pg,
    output logic [PG_W+PAGE_SHIFT-1:0] addr_next
);

    localparam int ADDR_W = PG_W + PAGE_SHIFT;

    logic [ADDR_W-1:0] inc;
    logic [ADDR_W-1:0] stop_addr;
    logic [ADDR_W-1:0] start_addr;

    // Plain increment with a jump from the stop boundary to the start page.
    always_comb begin
        inc        = addr_in + ADDR_W'(1);
        stop_addr  = {stop_pg, {PAGE_SHIFT{1'b0}}};
        start_addr = {start_pg, {PAGE_SHIFT{1'b0}}};
        addr_next  = (inc == stop_addr) ? start_addr : inc;
    end

endmodule

// File: rtl/rxr_ring_writer.sv
// Module: receive ring buffer writer (top).
// Accepts one frame at a time, streams its bytes into the ring after a
// four-byte gap, pads short frames with zeros, then fills in the header,
// advances the current page and pulses rx_done.
// Assumes the page inputs stay stable while a frame is in progress and that
// memory accepts one write in every cycle.
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int PG_W      = 8,
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ctl_stopped,
    input  logic [PG_W-1:0]            pg_start,
    input  logic [PG_W-1:0]            pg_stop,
    input  logic [PG_W-1:0]            pg_bound,
    input  logic                       cur_load,
    input  logic [PG_W-1:0]            cur_load_pg,
    input  logic                       rx_start,
    input  logic                       rx_valid,
    input  logic [7:0]                 rx_data,
    input  logic                       rx_last,
    output logic                       rx_ready,
    output logic                       mem_we,
    output logic [PG_W+PAGE_SHIFT-1:0] mem_addr,
    output logic [7:0]                 mem_wdata,
    output logic [PG_W-1:0]            cur_page,
    output logic                       rx_done
);

    localparam int ADDR_W     = PG_W + PAGE_SHIFT;
    localparam int NEED_BYTES = MAX_FRAME + HDR_BYTES;

    rx_state_e         state;
    logic [PG_W-1:0]   base_pg;
    logic [PG_W-1:0]   cur_pg_q;
    logic [ADDR_W-1:0] wptr;
    logic [LEN_W-1:0]  len;
    logic [1:0]        hdr_idx;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wdata_q;
    logic              done_q;

    logic              busy;
    logic              has_room;
    logic              accept;
    logic [ADDR_W-1:0] wptr_next;
    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] hdr_addr;
    logic [LEN_W-1:0]  len_inc;
    logic [LEN_W-1:0]  total;
    logic [15:0]       total16;
    logic [PG_W-1:0]   next_pg;
    logic [7:0]        hdr_byte;

    // Free-space test against a maximum-size frame plus its header.
    rxr_space #(
        .PG_W       (PG_W),
        .NEED_BYTES (NEED_BYTES)
    ) u_space (
        .start_pg (pg_start),
        .stop_pg  (pg_stop),
        .bound_pg (pg_bound),
        .cur_pg   (cur_pg_q),
        .has_room (has_room)
    );

    // Link page for the header and the current-page update.
    rxr_next #(
        .PG_W  (PG_W),
        .LEN_W (LEN_W)
    ) u_next (
        .base_pg   (base_pg),
        .total_len (total),
        .start_pg  (pg_start),
        .stop_pg   (pg_stop),
        .next_pg   (next_pg)
    );

    // Write pointer step with wrap from the stop page to the start page.
    rxr_step #(
        .PG_W (PG_W)
    ) u_step (
        .addr_in   (wptr),
        .start_pg  (pg_start),
        .stop_pg   (pg_stop),
        .addr_next (wptr_next)
    );

    // Derived values: acceptance, lengths, and the header byte and address.
    always_comb begin
        busy       = (state != RX_IDLE);
        rx_ready   = !busy && !ctl_stopped && has_room;
        accept     = rx_start && rx_ready;
        len_inc    = len + LEN_W'(1);
        total      = len + LEN_W'(HDR_BYTES);
        total16    = 16'(total);
        first_addr = {cur_pg_q, {PAGE_SHIFT{1'b0}}} + ADDR_W'(HDR_BYTES);
        hdr_addr   = {base_pg, {PAGE_SHIFT{1'b0}}} + ADDR_W'(hdr_idx);
        case (hdr_idx)
            2'd0:    hdr_byte = RX_STATUS_GOOD;
            2'd1:    hdr_byte = 8'(next_pg);
            2'd2:    hdr_byte = total16[7:0];
            default: hdr_byte = total16[15:8];
        endcase
    end

    // Frame sequencer: data, then padding, then header, then the page update and pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            base_pg  <= '0;
            cur_pg_q <= '0;
            wptr     <= '0;
            len      <= '0;
            hdr_idx  <= '0;
            we_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            we_q   <= 1'b0;
            done_q <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (cur_load) begin
                        cur_pg_q <= cur_load_pg;
                    end
                    if (accept) begin
                        base_pg <= cur_pg_q;
                        wptr    <= first_addr;
                        len     <= '0;
                        state   <= RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (rx_valid) begin
                        we_q    <= 1'b1;
                        addr_q  <= wptr;
                        wdata_q <= rx_data;
                        wptr    <= wptr_next;
                        len     <= len_inc;
                        if (rx_last) begin
                            hdr_idx <= '0;
                            state   <= (len_inc < LEN_W'(MIN_FRAME)) ? RX_PAD : RX_HDR;
                        end
                    end
                end
                RX_PAD: begin
                    we_q    <= 1'b1;
                    addr_q  <= wptr;
                    wdata_q <= 8'h00;
                    wptr    <= wptr_next;
                    len     <= len_inc;
                    if (len_inc == LEN_W'(MIN_FRAME)) begin
                        state <= RX_HDR;
                    end
                end
                RX_HDR: begin
                    we_q    <= 1'b1;
                    addr_q  <= hdr_addr;
                    wdata_q <= hdr_byte;
                    hdr_idx <= hdr_idx + 2'd1;
                    if (hdr_idx == 2'd3) begin
                        cur_pg_q <= next_pg;
                        done_q   <= 1'b1;
                        state    <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // Registered outputs to the memory port and the interrupt logic.
    always_comb begin
        mem_we    = we_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        cur_page  = cur_pg_q;
        rx_done   = done_q;
    end

endmodule

// File: rtl/rxr_ring_writer_chk.sv
// Module: property checker for the receive ring writer, bound to the top.
// Assumes pg_start < pg_stop and that the page inputs stay stable during a frame.
module rxr_ring_writer_chk #(
    parameter int PG_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_stopped,
    input logic              rx_ready,
    input logic              busy,
    input logic              mem_we,
    input logic [PG_W+7:0]   mem_addr,
    input logic [PG_W-1:0]   pg_start,
    input logic [PG_W-1:0]   pg_stop,
    input logic              rx_done,
    input logic [PG_W-1:0]   cur_page,
    input logic              cur_load
);

    // R7: every write lands inside the ring
    p_write_in_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr >= {pg_start, 8'h00}) && (mem_addr < {pg_stop, 8'h00}));

    // R2: a stopped controller never advertises room
    p_stopped_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_stopped |-> !rx_ready);

    // R8: the done pulse lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R9: no new frame is advertised while one is in progress
    p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rx_ready);

    // R3: writes come only from a frame that was in progress
    p_write_from_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(busy));

    // R10: the current page moves only on a load or at frame completion
    p_cur_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_page != $past(cur_page)) |-> (rx_done || $past(cur_load)));

endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(
    .PG_W (PG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_stopped (ctl_stopped),
    .rx_ready    (rx_ready),
    .busy        (busy),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .pg_start    (pg_start),
    .pg_stop     (pg_stop),
    .rx_done     (rx_done),
    .cur_page    (cur_page),
    .cur_load    (cur_load)
);

// File: tb/sim_rxr_ring_writer.sv
// Bench: a queue-based reference model of the expected writes and page updates, compared on every clock.
module sim_rxr_ring_writer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_stopped;
    logic [7:0]  pg_start, pg_stop, pg_bound;
    logic        cur_load;
    logic [7:0]  cur_load_pg;
    logic        rx_start, rx_valid, rx_last;
    logic [7:0]  rx_data;
    logic        rx_ready, mem_we, rx_done;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_page;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    finished = 1'b0;
    int    exp_addr[$];
    int    exp_data[$];
    string exp_tag[$];
    int    exp_done[$];
    int    cur_model;

    rxr_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .ctl_stopped(ctl_stopped),
        .pg_start(pg_start), .pg_stop(pg_stop), .pg_bound(pg_bound),
        .cur_load(cur_load), .cur_load_pg(cur_load_pg),
        .rx_start(rx_start), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_ready(rx_ready), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_page(cur_page), .rx_done(rx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Model of the space rule: free pages times 256 against 1514 + 4.
    function automatic bit model_ready(input int stopped, input int s, input int e, input int b, input int c);
        int fp;
        if (c < b) fp = b - c;
        else       fp = (e - s) - (c - b);
        return (stopped == 0) && (fp * 256 >= 1518);
    endfunction

    // Monitor: every write and every done pulse is compared against the model queues.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_we) begin
                if (exp_addr.size() == 0) begin
                    check(1'b0, "R2", "write with none expected", int'(mem_addr), -1);
                end else begin
                    int    ea;
                    int    ed;
                    string et;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    et = exp_tag.pop_front();
                    check(int'(mem_addr) == ea, et, "write address", int'(mem_addr), ea);
                    check(int'(mem_wdata) == ed, et, "write data", int'(mem_wdata), ed);
                end
            end
            if (rx_done) begin
                if (exp_done.size() == 0) begin
                    check(1'b0, "R8", "done with none expected", 1, 0);
                end else begin
                    int p;
                    p = exp_done.pop_front();
                    check(exp_addr.size() == 0, "R8", "writes pending at done", exp_addr.size(), 0);
                    check(int'(cur_page) == p, "R6", "current page at done", int'(cur_page), p);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG && !finished) begin
            n_bad++;
            $display("FAIL R8 watchdog expired: actual %0d expected below %0d", cyc, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic load_cur(input int pg);
        cur_load    = 1'b1;
        cur_load_pg = 8'(pg);
        tick();
        cur_load    = 1'b0;
        cur_model   = pg;
        check(int'(cur_page) == pg, "R10", "current page after load", int'(cur_page), pg);
    endtask

    task automatic chk_ready(input string tag);
        bit e;
        e = model_ready(int'(ctl_stopped), int'(pg_start), int'(pg_stop), int'(pg_bound), cur_model);
        check(rx_ready == e, tag, "ready", int'(rx_ready), int'(e));
    endtask

    task automatic send_frame(input int len, input bit accept, input bit gaps, input bit poke);
        int a, s, e, stored, tot, nxt;
        bit wrapped;
        s = int'(pg_start);
        e = int'(pg_stop);
        if (accept) begin
            a = cur_model * 256 + 4;
            wrapped = 1'b0;
            stored = (len < 60) ? 60 : len;
            for (int i = 0; i < stored; i++) begin
                exp_addr.push_back(a);
                exp_data.push_back((i < len) ? ((i * 13 + len) & 255) : 0);
                exp_tag.push_back(wrapped ? "R7" : ((i < len) ? "R3" : "R4"));
                a = a + 1;
                if (a == e * 256) begin
                    a = s * 256;
                    wrapped = 1'b1;
                end
            end
            tot = stored + 4;
            nxt = cur_model + ((tot + 4 + 255) >> 8);
            if (nxt >= e) nxt = nxt - (e - s);
            exp_addr.push_back(cur_model * 256);     exp_data.push_back(1);                exp_tag.push_back("R5");
            exp_addr.push_back(cur_model * 256 + 1); exp_data.push_back(nxt);              exp_tag.push_back("R6");
            exp_addr.push_back(cur_model * 256 + 2); exp_data.push_back(tot & 255);        exp_tag.push_back("R5");
            exp_addr.push_back(cur_model * 256 + 3); exp_data.push_back((tot >> 8) & 255); exp_tag.push_back("R5");
            exp_done.push_back(nxt);
            cur_model = nxt;
        end
        rx_start = 1'b1;
        tick();
        rx_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (gaps && (i % 4 == 2)) begin
                rx_valid = 1'b0;
                tick();
            end
            rx_valid = 1'b1;
            rx_data  = 8'((i * 13 + len) & 255);
            rx_last  = (i == len - 1);
            if (poke && i == 5) begin
                rx_start    = 1'b1;
                cur_load    = 1'b1;
                cur_load_pg = 8'h55;
            end
            tick();
            if (poke && i == 5) begin
                rx_start = 1'b0;
                cur_load = 1'b0;
                check(rx_ready == 1'b0, "R9", "ready during frame", int'(rx_ready), 0);
            end
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        for (int k = 0; k < 120 && exp_done.size() != 0; k++) tick();
        tick();
        tick();
        check(exp_done.size() == 0, "R8", "frame completion outstanding", exp_done.size(), 0);
        check(int'(cur_page) == cur_model, accept ? "R6" : "R2", "current page after frame",
              int'(cur_page), cur_model);
    endtask

    initial begin
        rst_n = 1'b0; ctl_stopped = 1'b1;
        pg_start = 8'h40; pg_stop = 8'h80; pg_bound = 8'h40;
        cur_load = 1'b0; cur_load_pg = 8'h00;
        rx_start = 1'b0; rx_valid = 1'b0; rx_last = 1'b0; rx_data = 8'h00;
        cur_model = 0;
        repeat (5) tick();
        rst_n = 1'b1;
        tick();
        // R10: reset state
        check(cur_page == 8'h00, "R10", "current page after reset", int'(cur_page), 0);
        check(mem_we == 1'b0, "R10", "write enable after reset", int'(mem_we), 0);
        check(rx_done == 1'b0, "R10", "done after reset", int'(rx_done), 0);
        check(rx_ready == 1'b0, "R2", "ready while stopped", int'(rx_ready), 0);

        load_cur(8'h40);
        ctl_stopped = 1'b0;
        tick();
        chk_ready("R1");                              // full ring: current equals boundary
        send_frame(20, 1'b1, 1'b0, 1'b0);             // R4 padding, R5 header
        send_frame(60, 1'b1, 1'b0, 1'b0);             // R4 exact minimum, no padding
        send_frame(59, 1'b1, 1'b1, 1'b0);             // R4 single pad byte, gaps in the byte stream
        send_frame(300, 1'b1, 1'b1, 1'b1);            // R9 start and load ignored mid-frame

        // R1 and R2: space threshold around six free pages
        load_cur(8'h42); pg_bound = 8'h46; tick(); chk_ready("R1");
        send_frame(100, 1'b0, 1'b0, 1'b0);
        pg_bound = 8'h47; tick(); chk_ready("R1");
        pg_bound = 8'h48; tick(); chk_ready("R1");
        check(rx_ready == 1'b1, "R1", "ready at six free pages", int'(rx_ready), 1);
        // current above boundary: the free count goes around the ring
        load_cur(8'h7C); pg_bound = 8'h41; tick(); chk_ready("R1");
        check(rx_ready == 1'b0, "R1", "ready with five free pages around the ring", int'(rx_ready), 0);

        // R7: data wraps from the stop page to the start page; R6 link wraps too
        load_cur(8'h7E); pg_bound = 8'h50; tick(); chk_ready("R1");
        send_frame(1000, 1'b1, 1'b0, 1'b0);

        // R6: next page lands exactly on the stop page and wraps to the start page
        load_cur(8'h7A); pg_bound = 8'h60; tick(); chk_ready("R1");
        send_frame(1514, 1'b1, 1'b0, 1'b0);

        // R2: stopped controller drops a frame despite free space
        load_cur(8'h40); pg_bound = 8'h40; ctl_stopped = 1'b1; tick();
        chk_ready("R2");
        send_frame(64, 1'b0, 1'b0, 1'b0);
        ctl_stopped = 1'b0; tick();
        chk_ready("R1");
        send_frame(61, 1'b1, 1'b1, 1'b0);             // R3 plain frame after the restart

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule